// File: doc/BRIEF.md
# Byte-Wide Boot Loader DMA Engine

This block moves data between a byte-wide external memory and an on-chip word memory. In the inbound direction it reads consecutive bytes, packs them most significant byte first into 24-bit program words or 16-bit data words, and writes each finished word into the internal memory port in one cycle. In the outbound direction it reads one internal word, splits it into bytes in the same order and writes them out. Software sets up the direction, word type, wait states, page, external address and internal address. It then starts the engine by writing a nonzero word count. A one-cycle interrupt marks the point where the count reaches zero.

An optional context-reset mode holds the processor core for the whole transfer and signals a restart at address 0 when the transfer finishes. When the boot strap is high during reset, the registers come up preset for a 32-word program load with the core held. The load starts by itself on the first cycle after reset is released. A pending core request for the external bus always wins over an engine byte access.

The FSM states are: `ST_IDLE` (waiting), `ST_FETCH` (inbound byte access), `ST_PUT` (internal word write), `ST_RDREQ` (internal word read request), `ST_RDCAP` (capture of the read word), `ST_STORE` (outbound byte access) and `ST_FINISH` (completion cycle). The transitions are:
- IDLE to FETCH or RDREQ on start, chosen by the direction bit.
- FETCH to PUT on the last byte of a word.
- PUT back to FETCH, or to FINISH on the last word.
- RDREQ to RDCAP to STORE.
- STORE back to RDREQ on the last byte of a word, or to FINISH on the last word.
- FINISH to IDLE.

A reset in boot mode enters FETCH directly.

Top module: `bytedma_engine`

## Requirements
- R1: In IDLE, a configuration write of a nonzero value to the count register (select 4) sets busy on the next cycle. A write of zero leaves the engine idle with a count of 0.
- R2: `word_count` drops by one after each word and reads as progress. The cycle in which it reaches zero raises `irq` for exactly one cycle, and busy is low in that cycle.
- R3: Every byte access keeps `bm_req` high for W+1 cycles, where W is the wait-state field (control bits 5:3).
- R4: With direction 0 (control bit 0) and type 0 (control bit 1), three consecutive bytes are packed most significant byte first into a 24-bit word. The word is written with one `im_we` cycle, `im_dm` is 0, and the internal address rises by one per word.
- R5: With type 1, two bytes form a 16-bit word in `im_wdata[15:0]`, upper bits 0, most significant byte first, with `im_dm` high.
- R6: While `core_ext_req` is high, `bm_req` stays low, the external address does not advance, and the interrupted access restarts its full wait count.
- R7: The external byte address is the page (select 1) joined above the 14-bit offset (select 3). It increments once per byte and carries from offset 0x3FFF into the next page.
- R8: With direction 1, each internal word read through `im_re` (data one cycle later on `im_rdata`) is written out with `bm_we`, most significant byte first: 3 bytes for type 0, 2 bytes from bits 15:0 for type 1.
- R9: With context-reset (control bit 2) at 0, `core_hold` stays low. At 1, `core_hold` is high while busy, and `core_restart` pulses in the completion cycle.
- R10: With `boot_mode` high during reset, the count reads 32, `core_hold` is high, and after release 32 program words load from external address 0 into internal addresses 0 to 31 with zero wait states.
- R11: Configuration writes are ignored unless the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 1 | Boot strap sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 page, 2 internal address, 3 external offset, 4 count |
| cfg_wdata | input | 16 | Configuration write data |
| word_count | output | 14 | Remaining word count |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| core_ext_req | input | 1 | Core request for the external bus (has priority) |
| core_hold | output | 1 | Holds the processor core |
| core_restart | output | 1 | Core restart at address 0 |
| bm_req | output | 1 | Byte memory access active |
| bm_we | output | 1 | Byte memory write |
| bm_addr | output | 22 | Byte address {page, offset} |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data, sampled at the end of the access |
| im_we | output | 1 | Internal word write |
| im_re | output | 1 | Internal word read request |
| im_dm | output | 1 | Internal memory type, 1 for data words |
| im_addr | output | 14 | Internal word address |
| im_wdata | output | 24 | Internal write data |
| im_rdata | input | 24 | Internal read data, valid the cycle after `im_re` |

## Verification
The assertions assume that `bm_rdata` is valid during the final cycle of each access, that `im_rdata` holds the read word in the cycle after `im_re`, and that the core bus request is a level that may rise and fall at any cycle boundary. The bench models byte memory as a pure function of `bm_addr`. It answers internal reads one half-cycle after the request, and it raises `core_ext_req` only in the middle of a transfer. All configuration writes are made while the engine is idle, except one deliberate write during a transfer.

// File: rtl/bytedma_pkg.sv
package bytedma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUT,
        ST_RDREQ,
        ST_RDCAP,
        ST_STORE,
        ST_FINISH
    } dma_state_e;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_PAGE = 3'd1;
    localparam logic [2:0] SEL_IADR = 3'd2;
    localparam logic [2:0] SEL_EADR = 3'd3;
    localparam logic [2:0] SEL_CNT  = 3'd4;
endpackage

// File: rtl/bytedma_regs.sv
module bytedma_regs #(
    parameter int EXT_AW     = 14,
    parameter int PAGE_W     = 8,
    parameter int INT_AW     = 14,
    parameter int CNT_W      = 14,
    parameter int WAIT_W     = 3,
    parameter int BOOT_WORDS = 32,
    localparam int PTR_W     = EXT_AW + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode,
    input  logic              idle,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              byte_step,
    input  logic              word_step,
    input  logic              core_ext_req,
    output logic              dir,
    output logic              wtype,
    output logic              ctx,
    output logic [WAIT_W-1:0] wait_cfg,
    output logic [PTR_W-1:0]  ext_ptr,
    output logic [INT_AW-1:0] int_addr,
    output logic [CNT_W-1:0]  count,
    output logic              start,
    output logic              cnt_one
);
    import bytedma_pkg::*;

    logic wr_ok;
    assign wr_ok   = cfg_we && idle;
    assign start   = wr_ok && (cfg_sel == SEL_CNT) && (|cfg_wdata[CNT_W-1:0]);
    assign cnt_one = (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir      <= 1'b0;
            wtype    <= 1'b0;
            ctx      <= boot_mode;
            wait_cfg <= '0;
            ext_ptr  <= '0;
            int_addr <= '0;
            count    <= boot_mode ? CNT_W'(BOOT_WORDS) : '0;
        end else begin
            if (wr_ok) begin
                unique case (cfg_sel)
                    SEL_CTRL: begin
                        dir      <= cfg_wdata[0];
                        wtype    <= cfg_wdata[1];
                        ctx      <= cfg_wdata[2];
                        wait_cfg <= cfg_wdata[3 +: WAIT_W];
                    end
                    SEL_PAGE: ext_ptr[EXT_AW +: PAGE_W] <= cfg_wdata[PAGE_W-1:0];
                    SEL_IADR: int_addr <= cfg_wdata[INT_AW-1:0];
                    SEL_EADR: ext_ptr[EXT_AW-1:0] <= cfg_wdata[EXT_AW-1:0];
                    SEL_CNT:  count <= cfg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (byte_step) ext_ptr <= ext_ptr + PTR_W'(1);
            if (word_step) begin
                int_addr <= int_addr + INT_AW'(1);
                count    <= count - CNT_W'(1);
            end
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_step |=> (count == $past(count) - CNT_W'(1)));

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ext_req && !idle) |=> $stable(ext_ptr));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(dir) && $stable(wtype) && $stable(ctx) && $stable(wait_cfg)));
endmodule

// File: rtl/bytedma_fsm.sv
module bytedma_fsm #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode,
    input  logic              start,
    input  logic              dir,
    input  logic              wtype,
    input  logic              ctx,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              core_ext_req,
    input  logic              cnt_one,
    output logic              idle,
    output logic              byte_step,
    output logic              word_step,
    output logic              word_load,
    output logic              bm_req,
    output logic              bm_we,
    output logic              im_we,
    output logic              im_re,
    output logic              busy,
    output logic              irq,
    output logic              core_hold,
    output logic              core_restart
);
    import bytedma_pkg::*;

    dma_state_e        state, state_nx;
    logic [WAIT_W-1:0] wcnt;
    logic [1:0]        bidx;
    logic [1:0]        last_idx;
    logic              in_access;
    logic              access_ok;
    logic              word_end;

    assign last_idx  = wtype ? 2'd1 : 2'd2;
    assign in_access = (state == ST_FETCH) || (state == ST_STORE);
    assign access_ok = in_access && !core_ext_req && (wcnt == wait_cfg);
    assign word_end  = access_ok && (bidx == last_idx);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = dir ? ST_RDREQ : ST_FETCH;
            ST_FETCH:  if (word_end) state_nx = ST_PUT;
            ST_PUT:    state_nx = cnt_one ? ST_FINISH : ST_FETCH;
            ST_RDREQ:  state_nx = ST_RDCAP;
            ST_RDCAP:  state_nx = ST_STORE;
            ST_STORE:  if (word_end) state_nx = cnt_one ? ST_FINISH : ST_RDREQ;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= boot_mode ? ST_FETCH : ST_IDLE;
            wcnt  <= '0;
            bidx  <= '0;
        end else begin
            state <= state_nx;
            if (!in_access || core_ext_req || access_ok) wcnt <= '0;
            else                                         wcnt <= wcnt + WAIT_W'(1);
            if (state == ST_IDLE)  bidx <= '0;
            else if (access_ok)    bidx <= (bidx == last_idx) ? 2'd0 : bidx + 2'd1;
        end
    end

    always_comb begin
        bm_req       = 1'b0;
        bm_we        = 1'b0;
        im_we        = 1'b0;
        im_re        = 1'b0;
        busy         = 1'b1;
        irq          = 1'b0;
        word_load    = 1'b0;
        core_restart = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_FETCH:  bm_req = !core_ext_req;
            ST_PUT:    im_we = 1'b1;
            ST_RDREQ:  im_re = 1'b1;
            ST_RDCAP:  word_load = 1'b1;
            ST_STORE: begin
                bm_req = !core_ext_req;
                bm_we  = !core_ext_req;
            end
            ST_FINISH: begin
                busy         = 1'b0;
                irq          = 1'b1;
                core_restart = ctx;
            end
            default:   busy = 1'b0;
        endcase
        idle      = (state == ST_IDLE);
        core_hold = ctx && (state != ST_IDLE);
        byte_step = access_ok;
        word_step = (state == ST_PUT) || ((state == ST_STORE) && word_end);
    end

    // R2
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_restart |=> !core_hold);

    // R4
    put_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_we && !dir) |-> $past(byte_step));
endmodule

// File: rtl/bytedma_packer.sv
module bytedma_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dir,
    input  logic        wtype,
    input  logic        byte_step,
    input  logic        word_load,
    input  logic [7:0]  bm_rdata,
    input  logic [23:0] im_rdata,
    output logic [7:0]  bm_wdata,
    output logic [23:0] im_wdata
);
    logic [23:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (word_load) begin
            sh <= wtype ? {im_rdata[15:0], 8'h00} : im_rdata;
        end else if (byte_step) begin
            sh <= {sh[15:0], dir ? 8'h00 : bm_rdata};
        end
    end

    assign bm_wdata = sh[23:16];
    assign im_wdata = wtype ? {8'h00, sh[15:0]} : sh;

    // R8
    load_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_load && !wtype) |=> (bm_wdata == $past(im_rdata[23:16])));
endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine #(
    parameter int EXT_AW     = 14,
    parameter int PAGE_W     = 8,
    parameter int INT_AW     = 14,
    parameter int CNT_W      = 14,
    parameter int WAIT_W     = 3,
    parameter int BOOT_WORDS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     boot_mode,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_sel,
    input  logic [15:0]              cfg_wdata,
    output logic [CNT_W-1:0]         word_count,
    output logic                     busy,
    output logic                     irq,
    input  logic                     core_ext_req,
    output logic                     core_hold,
    output logic                     core_restart,
    output logic                     bm_req,
    output logic                     bm_we,
    output logic [EXT_AW+PAGE_W-1:0] bm_addr,
    output logic [7:0]               bm_wdata,
    input  logic [7:0]               bm_rdata,
    output logic                     im_we,
    output logic                     im_re,
    output logic                     im_dm,
    output logic [INT_AW-1:0]        im_addr,
    output logic [23:0]              im_wdata,
    input  logic [23:0]              im_rdata
);
    localparam int PTR_W = EXT_AW + PAGE_W;

    logic              dir, wtype, ctx, idle, start, cnt_one;
    logic              byte_step, word_step, word_load;
    logic [WAIT_W-1:0] wait_cfg;
    logic [PTR_W-1:0]  ext_ptr;
    logic [INT_AW-1:0] int_addr;

    bytedma_regs #(
        .EXT_AW(EXT_AW), .PAGE_W(PAGE_W), .INT_AW(INT_AW),
        .CNT_W(CNT_W), .WAIT_W(WAIT_W), .BOOT_WORDS(BOOT_WORDS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .idle(idle),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .byte_step(byte_step), .word_step(word_step), .core_ext_req(core_ext_req),
        .dir(dir), .wtype(wtype), .ctx(ctx), .wait_cfg(wait_cfg),
        .ext_ptr(ext_ptr), .int_addr(int_addr), .count(word_count),
        .start(start), .cnt_one(cnt_one)
    );

    bytedma_fsm #(.WAIT_W(WAIT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .start(start),
        .dir(dir), .wtype(wtype), .ctx(ctx), .wait_cfg(wait_cfg),
        .core_ext_req(core_ext_req), .cnt_one(cnt_one), .idle(idle),
        .byte_step(byte_step), .word_step(word_step), .word_load(word_load),
        .bm_req(bm_req), .bm_we(bm_we), .im_we(im_we), .im_re(im_re),
        .busy(busy), .irq(irq), .core_hold(core_hold), .core_restart(core_restart)
    );

    bytedma_packer pack_i (
        .clk(clk), .rst_n(rst_n), .dir(dir), .wtype(wtype),
        .byte_step(byte_step), .word_load(word_load),
        .bm_rdata(bm_rdata), .im_rdata(im_rdata),
        .bm_wdata(bm_wdata), .im_wdata(im_wdata)
    );

    assign bm_addr = ext_ptr;
    assign im_addr = int_addr;
    assign im_dm   = wtype;

    // R6
    core_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ext_req |-> !bm_req);

    // R8
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_we |-> (dir && bm_req));
endmodule

// File: tb/bytedma_engine_tb.sv
module bytedma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [13:0] word_count;
    logic        busy, irq, core_hold, core_restart;
    logic        core_ext_req = 1'b0;
    logic        bm_req, bm_we;
    logic [21:0] bm_addr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        im_we, im_re, im_dm;
    logic [13:0] im_addr;
    logic [23:0] im_wdata;
    logic [23:0] im_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [13:0] log_addr [64];
    logic [23:0] log_data [64];
    logic        log_dm   [64];
    logic [13:0] log_cnt  [64];
    logic [7:0]  wmem     [1024];
    int im_n = 0, bmreq_cyc = 0, viol = 0, hold_cyc = 0, restart_n = 0;

    always #2 clk = ~clk;

    bytedma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .word_count(word_count), .busy(busy), .irq(irq),
        .core_ext_req(core_ext_req), .core_hold(core_hold), .core_restart(core_restart),
        .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .bm_rdata(bm_rdata), .im_we(im_we), .im_re(im_re), .im_dm(im_dm),
        .im_addr(im_addr), .im_wdata(im_wdata), .im_rdata(im_rdata)
    );

    function automatic logic [7:0] bm_byte(input logic [21:0] a);
        return a[7:0] + (a[21:14] * 8'd7) + 8'h3C;
    endfunction

    function automatic logic [23:0] im_word(input logic [13:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h10, a[7:0] ^ 8'h7E};
    endfunction

    assign bm_rdata = bm_byte(bm_addr);

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (im_we && im_n < 64) begin
                log_addr[im_n] = im_addr;
                log_data[im_n] = im_wdata;
                log_dm[im_n]   = im_dm;
                log_cnt[im_n]  = word_count;
                im_n++;
            end
            if (bm_req && bm_we) wmem[bm_addr[9:0]] = bm_wdata;
            if (bm_req) bmreq_cyc++;
            if (bm_req && core_ext_req) viol++;
            if (core_hold) hold_cyc++;
            if (core_restart) restart_n++;
        end
        if (im_re) im_rdata = im_word(im_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        im_n = 0; bmreq_cyc = 0; viol = 0; hold_cyc = 0; restart_n = 0;
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic dir, input logic typ, input logic ctx,
                         input logic [2:0] w, input logic [7:0] pg,
                         input logic [13:0] ea, input logic [13:0] ia);
        cfg_write(3'd0, {10'd0, w, ctx, typ, dir});
        cfg_write(3'd1, {8'd0, pg});
        cfg_write(3'd3, {2'd0, ea});
        cfg_write(3'd2, {2'd0, ia});
    endtask

    // Waits for the completion pulse; checks count, busy and pulse width (R2).
    task automatic wait_done(input string req);
        int n = 0;
        while (irq !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R2 irq seen"}, {31'd0, irq}, 32'd1);
        chk("R2 count zero at irq", {18'd0, word_count}, 32'd0);
        chk("R2 busy low at irq", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R2 irq one cycle", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset count", {18'd0, word_count}, 32'd0);
        chk("R9 reset hold", {31'd0, core_hold}, 32'd0);
        chk("R3 reset bm_req", {31'd0, bm_req}, 32'd0);
        chk("R2 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_zero_write();
        cfg_write(3'd4, 16'd0);
        chk("R1 zero count no start", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R1 zero count still idle", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_pack24();
        setup(1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 14'h0010, 14'd5);
        clear_logs();
        cfg_write(3'd4, 16'd3);
        chk("R1 start busy", {31'd0, busy}, 32'd1);
        wait_done("R4");
        chk("R4 word total", im_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R4 int addr", {18'd0, log_addr[k]}, 32'(5 + k));
            chk("R4 24-bit word", {8'd0, log_data[k]},
                {8'd0, bm_byte(22'(16 + 3*k)), bm_byte(22'(17 + 3*k)), bm_byte(22'(18 + 3*k))});
            chk("R4 pm type", {31'd0, log_dm[k]}, 32'd0);
            chk("R2 progress count", {18'd0, log_cnt[k]}, 32'(3 - k));
        end
        chk("R3 zero-wait bytes", bmreq_cyc, 9);
        chk("R9 no hold ctx0", hold_cyc, 0);
        chk("R9 no restart ctx0", restart_n, 0);
    endtask

    task automatic t_pack16_roll();
        logic [21:0] a0;
        setup(1'b0, 1'b1, 1'b0, 3'd2, 8'd2, 14'h3FFF, 14'd40);
        clear_logs();
        cfg_write(3'd4, 16'd2);
        // R11: writes while busy must not change wait states or count
        cfg_write(3'd0, 16'h0000);
        cfg_write(3'd4, 16'd7);
        wait_done("R5");
        chk("R11 word total", im_n, 2);
        chk("R3 wait 2 cycles", bmreq_cyc, 12);
        a0 = {8'd2, 14'h3FFF};
        for (int k = 0; k < 2; k++) begin
            chk("R7 R5 16-bit word", {8'd0, log_data[k]},
                {16'd0, bm_byte(a0 + 22'(2*k)), bm_byte(a0 + 22'(2*k + 1))});
            chk("R5 dm type", {31'd0, log_dm[k]}, 32'd1);
            chk("R11 progress", {18'd0, log_cnt[k]}, 32'(2 - k));
        end
    endtask

    task automatic t_priority();
        int n = 0;
        setup(1'b0, 1'b0, 1'b0, 3'd3, 8'd0, 14'h0200, 14'd60);
        clear_logs();
        cfg_write(3'd4, 16'd2);
        while (irq !== 1'b1 && n < 3000) begin
            if (n == 2) core_ext_req = 1'b1;
            if (n == 8) core_ext_req = 1'b0;
            @(negedge clk);
            n++;
        end
        core_ext_req = 1'b0;
        chk("R6 irq reached", {31'd0, irq}, 32'd1);
        chk("R6 no access under core req", viol, 0);
        chk("R6 words", im_n, 2);
        chk("R6 data", {8'd0, log_data[1]},
            {8'd0, bm_byte(22'h203), bm_byte(22'h204), bm_byte(22'h205)});
        chk("R6 restarted access count", (bmreq_cyc >= 24 && bmreq_cyc <= 27) ? 1 : 0, 1);
        @(negedge clk);
    endtask

    task automatic t_out();
        logic [23:0] w;
        setup(1'b1, 1'b0, 1'b1, 3'd1, 8'd0, 14'h0100, 14'h0020);
        clear_logs();
        cfg_write(3'd4, 16'd2);
        wait_done("R8");
        for (int k = 0; k < 2; k++) begin
            w = im_word(14'(32 + k));
            chk("R8 byte0", {24'd0, wmem[10'h100 + 10'(3*k)]}, {24'd0, w[23:16]});
            chk("R8 byte1", {24'd0, wmem[10'h101 + 10'(3*k)]}, {24'd0, w[15:8]});
            chk("R8 byte2", {24'd0, wmem[10'h102 + 10'(3*k)]}, {24'd0, w[7:0]});
        end
        chk("R9 hold while busy", (hold_cyc > 10) ? 1 : 0, 1);
        chk("R9 restart pulse", restart_n, 1);
        chk("R9 hold released", {31'd0, core_hold}, 32'd0);
        setup(1'b1, 1'b1, 1'b0, 3'd0, 8'd0, 14'h0180, 14'h0040);
        cfg_write(3'd4, 16'd1);
        wait_done("R8");
        w = im_word(14'h0040);
        chk("R8 16-bit hi", {24'd0, wmem[10'h180]}, {24'd0, w[15:8]});
        chk("R8 16-bit lo", {24'd0, wmem[10'h181]}, {24'd0, w[7:0]});
    endtask

    task automatic t_boot();
        @(negedge clk);
        boot_mode = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 boot count", {18'd0, word_count}, 32'd32);
        chk("R10 hold in reset", {31'd0, core_hold}, 32'd1);
        clear_logs();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 boot busy", {31'd0, busy}, 32'd1);
        wait_done("R10");
        chk("R10 words", im_n, 32);
        chk("R10 first addr", {18'd0, log_addr[0]}, 32'd0);
        chk("R10 last addr", {18'd0, log_addr[31]}, 32'd31);
        chk("R10 first word", {8'd0, log_data[0]},
            {8'd0, bm_byte(22'd0), bm_byte(22'd1), bm_byte(22'd2)});
        chk("R10 last word", {8'd0, log_data[31]},
            {8'd0, bm_byte(22'd93), bm_byte(22'd94), bm_byte(22'd95)});
        chk("R10 pm type", {31'd0, log_dm[31]}, 32'd0);
        chk("R10 restart", restart_n, 1);
        chk("R10 hold released", {31'd0, core_hold}, 32'd0);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_write();
        t_pack24();
        t_pack16_roll();
        t_priority();
        t_out();
        t_boot();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule